// File: doc/BRIEF.md
# Bidirectional Universal Bus Transceiver

This block couples two tri-state buses, A and B, through two independent storage lanes, one per direction. Each lane chooses, from its own controls, between three behaviours: a pass-through path where the far bus follows the near bus, a held state where the stored word is kept, and a clocked state where the near bus is loaded on a rising edge of the lane's clock. Each lane also has its own active-low output enable, which either drives the far bus or releases it to high impedance.

The A-to-B lane reads `a_io` and drives `b_io`. The B-to-A lane reads `b_io` and drives `a_io`. The two lanes are copies of one parameterized lane. Each lane's stored word is brought out on a separate observation port, so a system can inspect either lane without enabling both bus drivers at once. The data width is set by a parameter and defaults to 18 bits.

Top module: `ubt_top`

## Requirements
- R1: While `rst_ni` is low, both stored words read zero on `hold_ab_o` and `hold_ba_o`, whatever the clocks do.
- R2: With the A-to-B latch enable high (`le_ab_i`=1) and the A-to-B output enable active (`oe_ab_ni`=0), `b_io` equals `a_io` in the same cycle, with no clock edge needed.
- R3: With `le_ab_i`=0 and the clock enable active (`clken_ab_ni`=0), a rising edge of `clk_ab_i` loads `a_io` into the stored word. `hold_ab_o` shows the new word after that edge, and so does `b_io` when it is driven.
- R4: With `le_ab_i`=0 and `clken_ab_ni`=1, rising edges of `clk_ab_i` leave the stored word unchanged.
- R5: With `le_ab_i`=0 and no edge on `clk_ab_i`, changes on `a_io` do not reach `hold_ab_o` or the driven `b_io`.
- R6: While `le_ab_i`=1, every rising edge of `clk_ab_i` loads `a_io`, whatever the clock enable is. After `le_ab_i` falls, the lane holds the word taken at the last such edge.
- R7: With `oe_ab_ni`=1 the lane does not drive `b_io`, so a value driven onto `b_io` from outside reads back unchanged. With `oe_ba_ni`=1 the same holds for `a_io`.
- R8: The B-to-A lane follows R2 to R6 using `le_ba_i`, `clk_ba_i`, `clken_ba_ni` and `oe_ba_ni`, with the roles of `a_io` and `b_io` swapped. Activity on one lane never changes the other lane's stored word.
- R9: The data width is the parameter `WIDTH`, which defaults to 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low clear of both stored words |
| clk_ab_i | input | 1 | A-to-B lane clock, rising edge |
| clk_ba_i | input | 1 | B-to-A lane clock, rising edge |
| le_ab_i | input | 1 | A-to-B pass-through select, active high |
| le_ba_i | input | 1 | B-to-A pass-through select, active high |
| clken_ab_ni | input | 1 | A-to-B clock enable, active low |
| clken_ba_ni | input | 1 | B-to-A clock enable, active low |
| oe_ab_ni | input | 1 | Drive enable for `b_io`, active low |
| oe_ba_ni | input | 1 | Drive enable for `a_io`, active low |
| a_io | inout | WIDTH | Bus A |
| b_io | inout | WIDTH | Bus B |
| hold_ab_o | output | WIDTH | Stored word of the A-to-B lane |
| hold_ba_o | output | WIDTH | Stored word of the B-to-A lane |

## Verification
In one clock period a lane can be passing its input straight through and also loading that input at the clock edge. The R6 load, when the latch enable is high, is therefore provoked while the bus already shows the new word. The bench then drops the latch enable after changing the source without an edge, and judges that the held word is the one sampled at the last edge, not the later one. The second coincidence is one lane loading while the other lane holds: each sweep step reads both observation ports, so a store that leaks across lanes is caught at once.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  localparam int unsigned DEF_WIDTH = 18;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_PASS = 2'd2
  } lane_mode_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/ubt_mode_dec.sv
module ubt_mode_dec
  import ubt_pkg::*;
(
  input  logic       le_i,
  input  logic       clken_ni,
  output lane_mode_e mode_o
);
  always_comb begin
    if (le_i)           mode_o = MODE_PASS;
    else if (!clken_ni) mode_o = MODE_LOAD;
    else                mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/ubt_cell.sv
module ubt_cell
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lane_mode_e       mode_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  // pass mode also samples, so the word seen last stays after le drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= '0;
    else if (mode_i != MODE_HOLD) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             le_i,
  input  logic             clken_ni,
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] drv_o,
  output logic             drv_en_o,
  output logic [WIDTH-1:0] hold_o
);
  lane_mode_e       mode;
  logic [WIDTH-1:0] q;

  ubt_mode_dec u_dec (
    .le_i     (le_i),
    .clken_ni (clken_ni),
    .mode_o   (mode)
  );

  ubt_cell #(.WIDTH(WIDTH)) u_cell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .d_i    (src_i),
    .q_o    (q)
  );

  assign drv_o    = (mode == MODE_PASS) ? src_i : q;
  assign drv_en_o = ~oe_ni;
  assign hold_o   = q;
endmodule

// File: rtl/ubt_top.sv
module ubt_top
  import ubt_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             rst_ni,
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             le_ab_i,
  input  logic             le_ba_i,
  input  logic             clken_ab_ni,
  input  logic             clken_ba_ni,
  input  logic             oe_ab_ni,
  input  logic             oe_ba_ni,
  inout  wire  [WIDTH-1:0] a_io,
  inout  wire  [WIDTH-1:0] b_io,
  output logic [WIDTH-1:0] hold_ab_o,
  output logic [WIDTH-1:0] hold_ba_o
);
  // lane 0: A to B, lane 1: B to A
  logic [NUM_LANES-1:0] clk_l, le_l, clken_l, oe_l, drv_en_l;
  logic [WIDTH-1:0]     src_l  [NUM_LANES];
  logic [WIDTH-1:0]     drv_l  [NUM_LANES];
  logic [WIDTH-1:0]     hold_l [NUM_LANES];

  assign clk_l   = {clk_ba_i, clk_ab_i};
  assign le_l    = {le_ba_i, le_ab_i};
  assign clken_l = {clken_ba_ni, clken_ab_ni};
  assign oe_l    = {oe_ba_ni, oe_ab_ni};
  assign src_l[0] = a_io;
  assign src_l[1] = b_io;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    ubt_lane #(.WIDTH(WIDTH)) u_lane (
      .clk_i    (clk_l[g]),
      .rst_ni   (rst_ni),
      .le_i     (le_l[g]),
      .clken_ni (clken_l[g]),
      .oe_ni    (oe_l[g]),
      .src_i    (src_l[g]),
      .drv_o    (drv_l[g]),
      .drv_en_o (drv_en_l[g]),
      .hold_o   (hold_l[g])
    );
  end

  assign b_io = drv_en_l[0] ? drv_l[0] : {WIDTH{1'bz}};
  assign a_io = drv_en_l[1] ? drv_l[1] : {WIDTH{1'bz}};

  assign hold_ab_o = hold_l[0];
  assign hold_ba_o = hold_l[1];
endmodule

// File: rtl/ubt_checker.sv
module ubt_checker #(
  parameter int unsigned WIDTH = 18
) (
  input logic             rst_ni,
  input logic             clk_ab_i,
  input logic             clk_ba_i,
  input logic             le_ab_i,
  input logic             le_ba_i,
  input logic             clken_ab_ni,
  input logic             clken_ba_ni,
  input logic             oe_ab_ni,
  input logic [WIDTH-1:0] a_io,
  input logic [WIDTH-1:0] b_io,
  input logic [WIDTH-1:0] hold_ab_o,
  input logic [WIDTH-1:0] hold_ba_o
);
  // R2
  a_r2_pass_ab: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (le_ab_i && !oe_ab_ni) |-> (b_io == a_io));

  // R3
  a_r3_capture_ab: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!le_ab_i && !clken_ab_ni) |=> (hold_ab_o == $past(a_io)));

  // R4
  a_r4_hold_ab: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!le_ab_i && clken_ab_ni) |=> $stable(hold_ab_o));

  // R6
  a_r6_pass_load_ab: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    le_ab_i |=> (hold_ab_o == $past(a_io)));

  // R8
  a_r8_capture_ba: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (!le_ba_i && !clken_ba_ni) |=> (hold_ba_o == $past(b_io)));

  // R8
  a_r8_hold_ba: assert property (@(posedge clk_ba_i) disable iff (!rst_ni)
    (!le_ba_i && clken_ba_ni) |=> $stable(hold_ba_o));
endmodule

bind ubt_top ubt_checker #(.WIDTH(WIDTH)) u_chk (
  .rst_ni      (rst_ni),
  .clk_ab_i    (clk_ab_i),
  .clk_ba_i    (clk_ba_i),
  .le_ab_i     (le_ab_i),
  .le_ba_i     (le_ba_i),
  .clken_ab_ni (clken_ab_ni),
  .clken_ba_ni (clken_ba_ni),
  .oe_ab_ni    (oe_ab_ni),
  .a_io        (a_io),
  .b_io        (b_io),
  .hold_ab_o   (hold_ab_o),
  .hold_ba_o   (hold_ba_o)
);

// File: tb/sim_ubt_top.sv
`timescale 1ns/1ps
module sim_ubt_top;
  localparam int W = 18;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, clk_ab, clk_ba, le_ab, le_ba, cke_ab_n, cke_ba_n, oe_ab_n, oe_ba_n;
  logic [W-1:0] a_drv, b_drv;
  logic a_en, b_en;
  wire  [W-1:0] a_bus, b_bus;
  logic [W-1:0] hold_ab, hold_ba;

  assign a_bus = a_en ? a_drv : {W{1'bz}};
  assign b_bus = b_en ? b_drv : {W{1'bz}};

  ubt_top #(.WIDTH(W)) u0 (
    .rst_ni(rst_ni), .clk_ab_i(clk_ab), .clk_ba_i(clk_ba),
    .le_ab_i(le_ab), .le_ba_i(le_ba),
    .clken_ab_ni(cke_ab_n), .clken_ba_ni(cke_ba_n),
    .oe_ab_ni(oe_ab_n), .oe_ba_ni(oe_ba_n),
    .a_io(a_bus), .b_io(b_bus),
    .hold_ab_o(hold_ab), .hold_ba_o(hold_ba)
  );

  int checks = 0, fails = 0, cycles = 0;
  logic [W-1:0] m_ab, m_ba;
  logic [W-1:0] d;

  function automatic logic [W-1:0] pat(int k);
    logic [W-1:0] v;
    v = W'(k * 32'h0000_A5C3) ^ W'(k << 7) ^ W'(32'h15A5A);
    return v;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #1 clk_ab = 1'b1;
    #2 clk_ab = 1'b0;
    #1;
  endtask

  task automatic pulse_ba();
    #1 clk_ba = 1'b1;
    #2 clk_ba = 1'b0;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0;
    le_ab = 1'b0; le_ba = 1'b0; cke_ab_n = 1'b1; cke_ba_n = 1'b1;
    oe_ab_n = 1'b1; oe_ba_n = 1'b1;
    a_en = 1'b1; a_drv = pat(3); b_en = 1'b1; b_drv = pat(5);
    m_ab = '0; m_ba = '0;
    #3;
    // R1: reset clears, even with an enabled edge
    cke_ab_n = 1'b0; pulse_ab(); cke_ab_n = 1'b1;
    chk("R1 reset ab", hold_ab, '0);
    chk("R1 reset ba", hold_ba, '0);
    #2 rst_ni = 1'b1; #3;

    // A to B sweep over le / clken with many words
    b_en = 1'b0; oe_ab_n = 1'b0;
    for (int k = 0; k < 64; k++) begin
      d = pat(k);
      le_ab = k[0]; cke_ab_n = k[1];
      a_drv = d; #2;
      if (le_ab) chk("R2 pass ab", b_bus, d);
      else       chk("R5 no edge ab", b_bus, m_ab);
      pulse_ab();
      if (le_ab || !cke_ab_n) m_ab = d;
      if (le_ab)         chk("R6 pass load ab", hold_ab, m_ab);
      else if (!cke_ab_n) chk("R3 load ab", hold_ab, m_ab);
      else               chk("R4 gated hold ab", hold_ab, m_ab);
      if (!le_ab) chk("R3 driven ab", b_bus, m_ab);
      a_drv = ~d; #2;
      chk("R5 static clock ab", hold_ab, m_ab);
      chk("R8 ba untouched", hold_ba, m_ba);
    end

    // R6: word at last edge while passing is kept after le falls
    le_ab = 1'b1; cke_ab_n = 1'b1; a_drv = 18'h0F0F0; #2;
    pulse_ab(); m_ab = 18'h0F0F0;
    a_drv = 18'h30303; #2;
    chk("R6 pass follows", b_bus, 18'h30303);
    le_ab = 1'b0; #2;
    chk("R6 held after le fall", hold_ab, m_ab);
    chk("R6 driven after le fall", b_bus, m_ab);

    // R7: released B bus, lane holds all ones
    cke_ab_n = 1'b0; a_drv = ONES; pulse_ab(); m_ab = ONES; cke_ab_n = 1'b1;
    oe_ab_n = 1'b1; #1; b_drv = '0; b_en = 1'b1; #2;
    chk("R7 b released", b_bus, '0);
    b_drv = 18'h2AAAA; #2;
    chk("R7 b released pattern", b_bus, 18'h2AAAA);

    // B to A sweep
    a_en = 1'b0; oe_ba_n = 1'b0;
    for (int k = 0; k < 32; k++) begin
      d = pat(k + 100);
      le_ba = k[0]; cke_ba_n = k[1];
      b_drv = d; #2;
      if (le_ba) chk("R8 pass ba", a_bus, d);
      else       chk("R8 no edge ba", a_bus, m_ba);
      pulse_ba();
      if (le_ba || !cke_ba_n) m_ba = d;
      chk("R8 store ba", hold_ba, m_ba);
      b_drv = ~d; #2;
      chk("R8 static clock ba", hold_ba, m_ba);
      chk("R8 ab untouched", hold_ab, m_ab);
    end

    // R7 on A side
    le_ba = 1'b0; cke_ba_n = 1'b0; b_drv = ONES; pulse_ba(); m_ba = ONES; cke_ba_n = 1'b1;
    oe_ba_n = 1'b1; #1; a_drv = '0; a_en = 1'b1; #2;
    chk("R7 a released", a_bus, '0);

    // R9: width reaches top bit
    chk("R9 top bit ab", {17'd0, hold_ab[W-1]}, 18'd1);

    // R1: reset mid-run
    rst_ni = 1'b0; #2;
    chk("R1 midrun ab", hold_ab, '0);
    chk("R1 midrun ba", hold_ba, '0);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule